// File: doc/BRIEF.md
# Configurable Shift and Normalize Unit

This block is a 32-bit accumulator shift engine. Its behaviour comes from an 8-bit control word and a separate one-bit carry flag. The control word holds a shift direction, two enables that pick the fill and rotate behaviour, and a 5-bit count. A start command runs the programmed operation one bit position per clock. If the count is from 1 to 31, the accumulator shifts that many positions in one of four modes: a logical shift, a plain rotate, a shift that fills from the carry, or a 33-bit rotate through the carry.

If the count is zero, the start command runs a normalization instead. The accumulator moves left until its top bit is set, and the number of positions moved is written back into the count field. Software can then read how far the value was scaled. An initialize input returns the direction and count to zero and aborts any operation in progress.

The surrounding logic loads the accumulator, programs the control word and the carry flag, pulses start, and waits for the one-cycle done pulse.

Top module: `shn_unit`

## Requirements
- R1: After synchronous reset the control word, carry flag and accumulator read 0, and busy and done are low.
- R2: The control word has these fields: bit 7 is the direction (0 = left, 1 = right), bit 6 is the rotate enable, bit 5 is the carry enable, and bits 4..0 are the count. The control word and the carry flag are each written through their own write strobe and read back unchanged while the unit is idle.
- R3: With both enables at 0, each step shifts in a 0 at the vacated end and discards the bit shifted out. The carry flag is unchanged.
- R4: With rotate enable 1 and carry enable 0, the 32-bit accumulator rotates. The bit leaving one end enters the other end, and the carry flag is unchanged.
- R5: With rotate enable 0 and carry enable 1, the vacated end is filled from the carry flag and the outgoing bit is discarded. The carry flag keeps its value.
- R6: With both enables at 1, the accumulator and the carry flag rotate as one 33-bit ring. On a left shift bit 31 goes to the carry and the carry goes to bit 0. On a right shift bit 0 goes to the carry and the carry goes to bit 31.
- R7: A start with a count n from 1 to 31 holds busy high for exactly n cycles, one position per cycle. Done pulses for one cycle in the cycle after the last shift, and busy is low in that cycle.
- R8: A start with count 0 moves a nonzero accumulator left with zero fill until bit 31 is 1. This takes s shifts, where s is the number of leading zeros. The direction and both enables are ignored, and the carry flag is unchanged. Busy is high for s+1 cycles, and afterwards the count field reads s.
- R9: Normalizing an all-zero accumulator leaves it unchanged and leaves the count at 0, after one busy cycle.
- R10: While busy, start commands, control-word writes, carry writes and accumulator loads are ignored.
- R11: The initialize input clears the direction bit and the count field, and keeps both enables and the carry flag. If an operation is running, it stops at once with no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init | input | 1 | Initialize: clears direction and count, aborts an operation |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word write data |
| ctrl_rdata | output | 8 | Control word read data |
| carry_wr | input | 1 | Carry flag write strobe |
| carry_wdata | input | 1 | Carry flag write data |
| carry_rdata | output | 1 | Carry flag read data |
| acc_ld | input | 1 | Accumulator load strobe |
| acc_din | input | 32 | Accumulator load data |
| acc_q | output | 32 | Accumulator value |
| start | input | 1 | Start the programmed operation |
| busy | output | 1 | An operation is running |
| done | output | 1 | One-cycle pulse when an operation finishes |

## Verification
Random accumulators, carry values and control words cover all four modes in both directions. Asymmetric data tells apart zero fill, carry fill and wrap-around, and shows whether the carry was touched. Directed normalization cases use an all-zero accumulator, a value of 1 (31 shifts, the maximum) and a value with bit 31 already set (no shift); these separate the stop rule from the 31-shift limit. Count 31 in every mode checks the longest busy window. Writes, loads and a second start issued mid-operation, plus an initialize during a run, show that the state stays frozen and that an abort does not raise done.

// File: rtl/shn_pkg.sv
// Package: shared widths and the control-word layout for the shift and
// normalize unit. Assumes the accumulator width is a power of two so that the
// count field can address every shift from 1 to width-1.
package shn_pkg;
    localparam int SHN_ACC_W = 32;
    localparam int SHN_CNT_W = $clog2(SHN_ACC_W);

    // Control word: direction, rotate enable, carry enable, count (R2)
    typedef struct packed {
        logic                 dir;
        logic                 rot_en;
        logic                 cy_en;
        logic [SHN_CNT_W-1:0] cnt;
    } shn_ctrl_t;

    localparam int SHN_CTRL_W = $bits(shn_ctrl_t);
endpackage

// File: rtl/shn_step.sv
// Single-position shifter: purely combinational. From the accumulator, the
// carry flag and the mode bits it computes the accumulator and carry after one
// step. Assumes ACC_W >= 2.
module shn_step #(
    parameter int ACC_W = shn_pkg::SHN_ACC_W
) (
    input  logic [ACC_W-1:0] acc_in,
    input  logic             cy_in,
    input  logic             dir,
    input  logic             rot_en,
    input  logic             cy_en,
    output logic [ACC_W-1:0] acc_out,
    output logic             cy_out
);
    logic out_bit;
    logic fill_bit;

    // Pick the leaving bit and the bit that fills the vacated end
    always_comb begin
        out_bit  = dir ? acc_in[0] : acc_in[ACC_W-1];
        fill_bit = cy_en ? cy_in : (rot_en ? out_bit : 1'b0);
    end

    // Move one position and update the carry only for the 33-bit ring mode
    always_comb begin
        acc_out = dir ? {fill_bit, acc_in[ACC_W-1:1]} : {acc_in[ACC_W-2:0], fill_bit};
        cy_out  = (rot_en && cy_en) ? out_bit : cy_in;
    end
endmodule

// File: rtl/shn_ctrl_reg.sv
// Control word and carry flag storage. Software writes are blocked while an
// operation runs. The sequencer may write back a normalization count and
// update the carry. Initialize clears only the direction and the count.
module shn_ctrl_reg
    import shn_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  init,
    input  logic                  busy,
    input  logic                  ctrl_wr,
    input  logic [SHN_CTRL_W-1:0] ctrl_wdata,
    input  logic                  carry_wr,
    input  logic                  carry_wdata,
    input  logic                  wb_en,
    input  logic [SHN_CNT_W-1:0]  wb_cnt,
    input  logic                  cy_upd_en,
    input  logic                  cy_upd_val,
    output shn_ctrl_t             ctrl_q,
    output logic                  carry_q
);
    // Control word update: reset, initialize, count write-back, software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (init) begin
            ctrl_q.dir <= 1'b0;
            ctrl_q.cnt <= '0;
        end else if (wb_en) begin
            ctrl_q.cnt <= wb_cnt;
        end else if (ctrl_wr && !busy) begin
            ctrl_q <= shn_ctrl_t'(ctrl_wdata);
        end
    end

    // Carry flag update: ring-mode step result, or software write when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else if (cy_upd_en) begin
            carry_q <= cy_upd_val;
        end else if (carry_wr && !busy) begin
            carry_q <= carry_wdata;
        end
    end

    // R10: while running, only a write-back or an initialize may alter the word
    p_ctrl_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !init && !wb_en) |=> $stable(ctrl_q));

    // R11: initialize leaves direction and count at zero
    p_init_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (ctrl_q.dir == 1'b0 && ctrl_q.cnt == '0));

    // R5: without a ring-mode update the carry holds during an operation
    p_carry_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cy_upd_en) |=> $stable(carry_q));
endmodule

// File: rtl/shn_seq.sv
// Sequencer and accumulator: accepts load and start when idle, then shifts one
// position per cycle for a programmed count, or normalizes when the count is
// zero and reports the shift total. Assumes the control word is stable while
// busy (writes are blocked in shn_ctrl_reg).
module shn_seq
    import shn_pkg::*;
#(
    parameter int ACC_W = SHN_ACC_W,
    parameter int CNT_W = SHN_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             start,
    input  logic             acc_ld,
    input  logic [ACC_W-1:0] acc_din,
    input  shn_ctrl_t        ctrl,
    input  logic             carry,
    output logic [ACC_W-1:0] acc_q,
    output logic             busy,
    output logic             done,
    output logic             wb_en,
    output logic [CNT_W-1:0] wb_cnt,
    output logic             cy_upd_en,
    output logic             cy_upd_val
);
    logic             norm_q;
    logic [CNT_W-1:0] cnt_q;
    logic             norm_stop;
    logic [ACC_W-1:0] step_acc;
    logic             step_cy;

    shn_step #(.ACC_W(ACC_W)) u_step (
        .acc_in  (acc_q),
        .cy_in   (carry),
        .dir     (norm_q ? 1'b0 : ctrl.dir),
        .rot_en  (norm_q ? 1'b0 : ctrl.rot_en),
        .cy_en   (norm_q ? 1'b0 : ctrl.cy_en),
        .acc_out (step_acc),
        .cy_out  (step_cy)
    );

    // Normalization stops on a set top bit, an all-zero value or the count limit
    always_comb begin
        norm_stop  = acc_q[ACC_W-1] || (acc_q == '0) || (&cnt_q);
        wb_en      = busy && norm_q && norm_stop && !init;
        wb_cnt     = cnt_q;
        cy_upd_en  = busy && !norm_q && ctrl.rot_en && ctrl.cy_en && !init;
        cy_upd_val = step_cy;
    end

    // Operation state: accept commands when idle, step when busy, abort on init
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
            norm_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done <= 1'b0;
            if (init) begin
                busy <= 1'b0;
            end else if (!busy) begin
                if (acc_ld) begin
                    acc_q <= acc_din;
                end
                if (start) begin
                    busy   <= 1'b1;
                    norm_q <= (ctrl.cnt == '0);
                    cnt_q  <= ctrl.cnt;
                end
            end else if (norm_q) begin
                if (norm_stop) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    acc_q <= step_acc;
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                acc_q <= step_acc;
                if (cnt_q == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    // R7: done lasts a single cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: busy is low whenever done is raised
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: a finished normalization leaves the top bit set or a zero value
    p_norm_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && norm_q) |-> (acc_q[ACC_W-1] || acc_q == '0));

    // R10: the accumulator moves only by a load when idle or by a step when busy
    p_acc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !acc_ld) |=> $stable(acc_q));

    // R4: a plain rotate keeps the number of ones
    p_rotate_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !norm_q && ctrl.rot_en && !ctrl.cy_en && !init)
        |=> ($countones(acc_q) == $countones($past(acc_q))));

    // R6: the 33-bit ring keeps the number of ones across accumulator and carry
    p_ring_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !norm_q && ctrl.rot_en && ctrl.cy_en && !init)
        |=> ($countones({acc_q, carry}) == $countones($past({acc_q, carry}))));
endmodule

// File: rtl/shn_unit.sv
// Top level of the shift and normalize unit: connects the control storage to
// the sequencer and brings out the read paths. Assumes the register, load and
// start inputs are synchronous to clk.
module shn_unit
    import shn_pkg::*;
#(
    parameter int ACC_W = SHN_ACC_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  init,
    input  logic                  ctrl_wr,
    input  logic [SHN_CTRL_W-1:0] ctrl_wdata,
    output logic [SHN_CTRL_W-1:0] ctrl_rdata,
    input  logic                  carry_wr,
    input  logic                  carry_wdata,
    output logic                  carry_rdata,
    input  logic                  acc_ld,
    input  logic [ACC_W-1:0]      acc_din,
    output logic [ACC_W-1:0]      acc_q,
    input  logic                  start,
    output logic                  busy,
    output logic                  done
);
    shn_ctrl_t            ctrl_q;
    logic                 carry_q;
    logic                 wb_en;
    logic [SHN_CNT_W-1:0] wb_cnt;
    logic                 cy_upd_en;
    logic                 cy_upd_val;

    shn_ctrl_reg u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .init        (init),
        .busy        (busy),
        .ctrl_wr     (ctrl_wr),
        .ctrl_wdata  (ctrl_wdata),
        .carry_wr    (carry_wr),
        .carry_wdata (carry_wdata),
        .wb_en       (wb_en),
        .wb_cnt      (wb_cnt),
        .cy_upd_en   (cy_upd_en),
        .cy_upd_val  (cy_upd_val),
        .ctrl_q      (ctrl_q),
        .carry_q     (carry_q)
    );

    shn_seq #(.ACC_W(ACC_W), .CNT_W(SHN_CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (init),
        .start      (start),
        .acc_ld     (acc_ld),
        .acc_din    (acc_din),
        .ctrl       (ctrl_q),
        .carry      (carry_q),
        .acc_q      (acc_q),
        .busy       (busy),
        .done       (done),
        .wb_en      (wb_en),
        .wb_cnt     (wb_cnt),
        .cy_upd_en  (cy_upd_en),
        .cy_upd_val (cy_upd_val)
    );

    // Read paths expose the stored control word and carry flag (R2)
    always_comb begin
        ctrl_rdata  = ctrl_q;
        carry_rdata = carry_q;
    end
endmodule

// File: tb/shn_unit_tb_top.sv
`timescale 1ns/1ps
module shn_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [7:0]  ctrl_wdata = '0;
    logic [7:0]  ctrl_rdata;
    logic        carry_wr = 1'b0;
    logic        carry_wdata = 1'b0;
    logic        carry_rdata;
    logic        acc_ld = 1'b0;
    logic [31:0] acc_din = '0;
    logic [31:0] acc_q;
    logic        start = 1'b0;
    logic        busy;
    logic        done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    shn_unit dut_i (
        .clk(clk), .rst_n(rst_n), .init(init),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .carry_wr(carry_wr), .carry_wdata(carry_wdata), .carry_rdata(carry_rdata),
        .acc_ld(acc_ld), .acc_din(acc_din), .acc_q(acc_q),
        .start(start), .busy(busy), .done(done)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference: apply the programmed count of single steps, returns {carry, acc}
    function automatic logic [32:0] ref_shift(logic [31:0] a, logic c, logic [7:0] ct);
        logic o, f;
        for (int i = 0; i < int'(ct[4:0]); i++) begin
            o = ct[7] ? a[0] : a[31];
            f = ct[5] ? c : (ct[6] ? o : 1'b0);
            a = ct[7] ? {f, a[31:1]} : {a[30:0], f};
            if (ct[6] && ct[5]) c = o;
        end
        return {c, a};
    endfunction

    // Reference: leading zero count, 0 for an all-zero value
    function automatic int ref_lz(logic [31:0] a);
        if (a == 0) return 0;
        for (int i = 31; i >= 0; i--) if (a[i]) return 31 - i;
        return 0;
    endfunction

    function automatic string mode_tag(logic [7:0] ct);
        if (ct[4:0] == 0) return "R8";
        case (ct[6:5])
            2'b00:   return "R3";
            2'b10:   return "R4";
            2'b01:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic wr_ctrl(input logic [7:0] v);
        ctrl_wr = 1'b1; ctrl_wdata = v; @(negedge clk); ctrl_wr = 1'b0;
    endtask
    task automatic wr_carry(input logic v);
        carry_wr = 1'b1; carry_wdata = v; @(negedge clk); carry_wr = 1'b0;
    endtask
    task automatic load(input logic [31:0] v);
        acc_ld = 1'b1; acc_din = v; @(negedge clk); acc_ld = 1'b0;
    endtask

    // Pulse start and count negedges until done; returns the count
    task automatic go(output int cyc);
        start = 1'b1; @(negedge clk); start = 1'b0; cyc = 1;
        while (!done && cyc < 100) begin @(negedge clk); cyc++; end
    endtask

    // Full operation with expected results derived from the requirements
    task automatic run_case(input logic [31:0] a, input logic c, input logic [7:0] ct);
        logic [32:0] r;
        logic [7:0]  ect;
        int          ecyc, cyc, s;
        string       tg;
        tg = mode_tag(ct);
        load(a); wr_ctrl(ct); wr_carry(c);
        if (ct[4:0] == 0) begin
            s    = ref_lz(a);
            r    = {c, a << s};
            ect  = {ct[7:5], 5'(s)};
            ecyc = s + 2;
        end else begin
            r    = ref_shift(a, c, ct);
            ect  = ct;
            ecyc = int'(ct[4:0]) + 1;
        end
        go(cyc);
        check(tg, "accumulator", acc_q, r[31:0]);
        check(tg, "carry", {31'd0, carry_rdata}, {31'd0, r[32]});
        check(tg, "control word", {24'd0, ctrl_rdata}, {24'd0, ect});
        check("R7", "cycles to done", cyc, ecyc);
        check("R7", "busy low at done", {31'd0, busy}, 32'd0);
        @(negedge clk);
        check("R7", "done one cycle", {31'd0, done}, 32'd0);
    endtask

    initial begin : watchdog
        #2000000;
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int cyc;
        logic [31:0] a;
        logic [7:0]  ct;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "ctrl", {24'd0, ctrl_rdata}, 0);
        check("R1", "carry", {31'd0, carry_rdata}, 0);
        check("R1", "acc", acc_q, 0);
        check("R1", "busy/done", {30'd0, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 field readback
        wr_ctrl(8'hB5); check("R2", "ctrl readback", {24'd0, ctrl_rdata}, 32'hB5);
        wr_carry(1'b1); check("R2", "carry readback", {31'd0, carry_rdata}, 1);
        wr_carry(1'b0); check("R2", "carry clear", {31'd0, carry_rdata}, 0);

        // Directed modes
        run_case(32'h8000_0001, 1'b0, 8'h01);   // R3 left
        run_case(32'h8000_0001, 1'b1, 8'h81);   // R3 right, carry ignored
        run_case(32'h8000_0001, 1'b0, 8'h41);   // R4 left wrap
        run_case(32'h8000_0001, 1'b0, 8'hC1);   // R4 right wrap
        run_case(32'h0000_0000, 1'b1, 8'h23);   // R5 left fill ones
        run_case(32'h0000_0000, 1'b1, 8'hA3);   // R5 right fill ones
        run_case(32'h8000_0000, 1'b0, 8'h61);   // R6 left to carry
        run_case(32'h0000_0001, 1'b0, 8'hE1);   // R6 right to carry
        for (int m = 0; m < 8; m++) run_case(32'hC3A5_0F96, m[0], {m[2:0], 5'd31});
        // R8/R9 normalization corners
        run_case(32'h0000_0001, 1'b1, 8'hE0);   // R8: 31 shifts, mode bits ignored
        run_case(32'h8000_0000, 1'b0, 8'h00);   // R8: already normalized
        run_case(32'h0001_2345, 1'b0, 8'h80);   // R8
        run_case(32'h0000_0000, 1'b1, 8'h60);   // R9: zero value

        // Random mix
        for (int k = 0; k < 200; k++) begin
            a  = $urandom;
            a  = a >> ($urandom % 32);
            ct = 8'($urandom);
            if ($urandom % 4 == 0) ct[4:0] = 5'd0;
            run_case(a, 1'($urandom), ct);
        end

        // R10: writes, load and start while busy are ignored
        load(32'hF0F0_1234); wr_ctrl(8'h05); wr_carry(1'b0);
        start = 1'b1; @(negedge clk); start = 1'b0;
        ctrl_wr = 1'b1; ctrl_wdata = 8'h9F; carry_wr = 1'b1; carry_wdata = 1'b1;
        acc_ld = 1'b1; acc_din = 32'h0; start = 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0; carry_wr = 1'b0; acc_ld = 1'b0; start = 1'b0;
        cyc = 2;
        while (!done && cyc < 100) begin @(negedge clk); cyc++; end
        check("R10", "acc after busy writes", acc_q, 32'hF0F0_1234 << 5);
        check("R10", "ctrl after busy write", {24'd0, ctrl_rdata}, 32'h05);
        check("R10", "carry after busy write", {31'd0, carry_rdata}, 0);
        check("R10", "cycles", cyc, 6);
        repeat (3) @(negedge clk);
        check("R10", "no restart", {31'd0, busy}, 0);

        // R11: initialize mid-operation aborts and clears direction and count
        load(32'h1234_5678); wr_ctrl(8'hA7); wr_carry(1'b1);
        start = 1'b1; @(negedge clk); start = 1'b0;
        @(negedge clk);
        init = 1'b1; @(negedge clk); init = 1'b0;
        check("R11", "busy after init", {31'd0, busy}, 0);
        cyc = 0;
        repeat (10) begin @(negedge clk); if (done) cyc++; end
        check("R11", "no done after abort", cyc, 0);
        check("R11", "ctrl after init", {24'd0, ctrl_rdata}, 32'h20);
        check("R11", "carry kept", {31'd0, carry_rdata}, 1);
        // R11 idle initialize
        wr_ctrl(8'hFF);
        init = 1'b1; @(negedge clk); init = 1'b0;
        check("R11", "idle init", {24'd0, ctrl_rdata}, 32'h60);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule